// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it over a 32-bit register bus with separate read and write strobes and a word address. Each pin can be an input or a driven output, and software can read the synchronized pin state. Outputs are changed through separate write-one-to-set and write-one-to-clear registers, so updating one pin never needs a read-modify-write of its neighbours.

Each pin can capture a rising edge, a falling edge or both into a sticky status bit, which stays set until software writes a one to it. A single interrupt line is high while any status bit is set. Every pin also has a 2-bit function selector that steers it between plain GPIO use and other on-chip functions. The pad drivers and the muxing to other peripherals lie outside this block. It only exports the output value, the output enable and the selector for each pin.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, padOe, padOut, altSel and irqOut are all zero, and the edge status and edge enables read back as zero.
- R2: Registers form eight groups of NW = NUM_PINS/32 words each. The groups are level=0, direction=1, set=2, clear=3, rising enable=4, falling enable=5, status=6 and function select=7, and the function-select group holds 2×NW words. For a 1-bit feature of pin p, the word address is group×NW + p/32 (the byte address is four times this), and the pin uses bit p mod 32.
- R3: A direction bit of 1 makes the pin an output and drives its padOe bit high. A 0 makes it an input. The direction words read back as written.
- R4: Writing a 1 to a bit of a set word drives that pin's padOut high on the next clock. Bits written as 0 leave their pins unchanged.
- R5: Writing a 1 to a bit of a clear word drives that pin's padOut low on the next clock. Bits written as 0 leave their pins unchanged.
- R6: Reading a level word returns the pad inputs after a two-flop synchronizer. A pad change is visible from the second clock edge after it. Writes to the level group have no effect.
- R7: A pin whose rising-enable bit is set sets its status bit on a low-to-high transition of its synchronized input.
- R8: A pin whose falling-enable bit is set sets its status bit on a high-to-low transition. A pin with both enables set captures both kinds of edge.
- R9: Status bits are sticky until a 1 is written to them. Writing all ones clears every pending bit. irqOut is high exactly while any status bit is set.
- R10: If an edge on a pin is captured in the same cycle as a write-one-to-clear of that pin's status bit, the bit stays set.
- R11: The function-select field of pin p is 2 bits wide. It sits in word p/16 of its group at bit 2×(p mod 16), drives altSel[2p+1:2p], and reads back as written. A value of 0 means plain GPIO.
- R12: Reads of the set and clear groups return zero. Accesses at word addresses of 9×NW and above read zero and change nothing.
- R13: A transition on a pin whose matching edge enable is clear does not set its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when busRd is low |
| padIn | input | NUM_PINS | Raw asynchronous pin inputs |
| padOut | output | NUM_PINS | Output value for each pin |
| padOe | output | NUM_PINS | Output enable for each pin |
| altSel | output | 2×NUM_PINS | Function selector, 2 bits per pin |
| irqOut | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach is a new edge that lands in the same cycle as a clear of its own status bit. The edge only takes effect after the synchronizer and edge-detect registers, so the bench places the clear write by counting clock edges from the pad change. It also first confirms that the bit is already set, so a design that lets the clear win would read back zero. Edge enables are spread across pins so that each pin separates rising-only, falling-only, both and neither in one pad sweep. A high-word pin checks the word-index arithmetic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register group index; the order fixes the address map.
  typedef enum logic [2:0] {
    GRP_LVL  = 3'd0,
    GRP_DIR  = 3'd1,
    GRP_SET  = 3'd2,
    GRP_CLR  = 3'd3,
    GRP_RISE = 3'd4,
    GRP_FALL = 3'd5,
    GRP_STAT = 3'd6,
    GRP_ALT  = 3'd7
  } grp_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic wr;
    logic rd;
    grp_e grp;
    logic [7:0] sub;   // word index inside the group
  } bus_stb_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output bus_stb_t          stb
);
  localparam int NW       = NUM_PINS / 32;
  localparam int ALT_BASE = 7 * NW;
  localparam int WORD_END = 9 * NW;

  int unsigned wordIdx;
  logic inRange;

  always_comb begin
    wordIdx = 32'(busAddr);
    inRange = 1'b0;
    stb     = '0;
    stb.grp = GRP_LVL;
    if (wordIdx < ALT_BASE) begin
      inRange = 1'b1;
      stb.grp = grp_e'(3'(wordIdx / NW));
      stb.sub = 8'(wordIdx % NW);
    end else if (wordIdx < WORD_END) begin
      inRange = 1'b1;
      stb.grp = GRP_ALT;
      stb.sub = 8'(wordIdx - ALT_BASE);
    end
    stb.wr = busWr & inRange;
    stb.rd = busRd & inRange;
  end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bus_stb_t              stb,
  input  logic [31:0]           wdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [31:0]           rdata,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [2*NUM_PINS-1:0] altSel,
  output logic                  irqOut
);
  localparam int NW = NUM_PINS / 32;
  localparam int AW = 2 * NW;

  logic [NUM_PINS-1:0] lvl, lvlPrev, hit, clrMask;
  logic [NUM_PINS-1:0] dirQ, outQ, riseQ, fallQ, statQ;
  logic [NUM_PINS-1:0] dirD, outD, riseD, fallD, statD;
  logic [2*NUM_PINS-1:0] altQ, altD;

  gpio_bank_sync #(.WIDTH(NUM_PINS)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (lvl)
  );

  assign hit = (lvl & ~lvlPrev & riseQ) | (~lvl & lvlPrev & fallQ);

  // Next-state of the writable registers.
  always_comb begin
    dirD    = dirQ;
    outD    = outQ;
    riseD   = riseQ;
    fallD   = fallQ;
    altD    = altQ;
    clrMask = '0;
    if (stb.wr) begin
      for (int k = 0; k < NW; k++) begin
        if (stb.sub == 8'(k)) begin
          case (stb.grp)
            GRP_DIR:  dirD[k*32 +: 32]    = wdata;
            GRP_SET:  outD[k*32 +: 32]    = outQ[k*32 +: 32] | wdata;
            GRP_CLR:  outD[k*32 +: 32]    = outQ[k*32 +: 32] & ~wdata;
            GRP_RISE: riseD[k*32 +: 32]   = wdata;
            GRP_FALL: fallD[k*32 +: 32]   = wdata;
            GRP_STAT: clrMask[k*32 +: 32] = wdata;
            default:  ;
          endcase
        end
      end
      if (stb.grp == GRP_ALT) begin
        for (int k = 0; k < AW; k++) begin
          if (stb.sub == 8'(k)) altD[k*32 +: 32] = wdata;
        end
      end
    end
    // A fresh edge outranks a clear in the same cycle.
    statD = (statQ & ~clrMask) | hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlPrev <= '0;
      dirQ    <= '0;
      outQ    <= '0;
      riseQ   <= '0;
      fallQ   <= '0;
      statQ   <= '0;
      altQ    <= '0;
    end else begin
      lvlPrev <= lvl;
      dirQ    <= dirD;
      outQ    <= outD;
      riseQ   <= riseD;
      fallQ   <= fallD;
      statQ   <= statD;
      altQ    <= altD;
    end
  end

  // Read multiplexer; set and clear groups read as zero.
  always_comb begin
    rdata = '0;
    if (stb.rd) begin
      for (int k = 0; k < NW; k++) begin
        if (stb.sub == 8'(k)) begin
          case (stb.grp)
            GRP_LVL:  rdata = lvl[k*32 +: 32];
            GRP_DIR:  rdata = dirQ[k*32 +: 32];
            GRP_RISE: rdata = riseQ[k*32 +: 32];
            GRP_FALL: rdata = fallQ[k*32 +: 32];
            GRP_STAT: rdata = statQ[k*32 +: 32];
            default:  ;
          endcase
        end
      end
      if (stb.grp == GRP_ALT) begin
        for (int k = 0; k < AW; k++) begin
          if (stb.sub == 8'(k)) rdata = altQ[k*32 +: 32];
        end
      end
    end
  end

  assign padOut = outQ;
  assign padOe  = dirQ;
  assign altSel = altQ;
  assign irqOut = |statQ;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [2*NUM_PINS-1:0] altSel,
  output logic                  irqOut
);
  bus_stb_t stb;

  gpio_bank_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uDec (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .padIn  (padIn),
    .rdata  (busRdata),
    .padOut (padOut),
    .padOe  (padOe),
    .altSel (altSel),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWr,
  input logic                  busRd,
  input logic [31:0]           busWdata,
  input logic [31:0]           busRdata,
  input logic [NUM_PINS-1:0]   padOut,
  input logic [NUM_PINS-1:0]   padOe,
  input logic [2*NUM_PINS-1:0] altSel,
  input logic                  irqOut
);
  localparam int NW = NUM_PINS / 32;
  localparam logic [ADDR_W-1:0] DIR0  = ADDR_W'(1 * NW);
  localparam logic [ADDR_W-1:0] SET0  = ADDR_W'(2 * NW);
  localparam logic [ADDR_W-1:0] CLR0  = ADDR_W'(3 * NW);
  localparam logic [ADDR_W-1:0] RISE0 = ADDR_W'(4 * NW);
  localparam int WORD_END = 9 * NW;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0 && altSel == '0 && !irqOut));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == DIR0) |=> (padOe[31:0] == $past(busWdata)));

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == SET0) |=> ((padOut[31:0] & $past(busWdata)) == $past(busWdata)));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == CLR0) |=> ((padOut[31:0] & $past(busWdata)) == 32'h0));

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(busWr));

  assert_zero_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && ((busAddr >= SET0 && busAddr < RISE0) || 32'(busAddr) >= WORD_END))
      |-> (busRdata == 32'h0));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busRd    (busRd),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .altSel   (altSel),
  .irqOut   (irqOut)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int N = 64;
  localparam int AW = 8;
  // Word addresses for NW = 2
  localparam logic [7:0] A_LVL0 = 8'd0,  A_LVL1 = 8'd1,  A_DIR0 = 8'd2;
  localparam logic [7:0] A_SET0 = 8'd4,  A_SET1 = 8'd5,  A_CLR0 = 8'd6;
  localparam logic [7:0] A_RIS0 = 8'd8,  A_RIS1 = 8'd9,  A_FAL0 = 8'd10;
  localparam logic [7:0] A_ST0  = 8'd12, A_ST1  = 8'd13;
  localparam logic [7:0] A_ALT1 = 8'd15, A_ALT3 = 8'd17, A_OUT  = 8'd18;

  localparam int S_RD = 0, S_OUTLO = 1, S_OUTHI = 2, S_OE = 3, S_IRQ = 4, S_ALTHI = 5, S_ALTLO = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic [N-1:0] padIn = '0, padOut, padOe;
  logic [2*N-1:0] altSel;
  logic irqOut;

  gpio_bank_ctrl #(.NUM_PINS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .altSel(altSel), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;
  logic [31:0] act;
  logic obsReq = 1'b0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  // Monitor: mid-cycle, pops expected items and compares.
  always @(negedge clk) begin
    if (obsReq && q.size() > 0) begin
      it = q.pop_front();
      case (it.sel)
        S_RD:    act = busRdata;
        S_OUTLO: act = padOut[31:0];
        S_OUTHI: act = padOut[63:32];
        S_OE:    act = padOe[31:0];
        S_IRQ:   act = {31'h0, irqOut};
        S_ALTHI: act = altSel[63:32];
        default: act = altSel[31:0];
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic obs(int sel, logic [7:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    busAddr = a; busRd = (sel == S_RD);
    q.push_back('{sel, e, tag});
    obsReq = 1'b1;
    @(posedge clk); #1;
    busRd = 1'b0; obsReq = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic setPad(logic [N-1:0] v);
    @(posedge clk); #1;
    padIn = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(posedge clk); #1; rstN = 1'b1;
    // R1 reset state
    obs(S_OE, 0, 32'h0, "R1 padOe");
    obs(S_OUTLO, 0, 32'h0, "R1 padOut");
    obs(S_IRQ, 0, 32'h0, "R1 irqOut");
    obs(S_ALTLO, 0, 32'h0, "R1 altSel");
    obs(S_RD, A_ST0, 32'h0, "R1 status");
    obs(S_RD, A_RIS0, 32'h0, "R1 rise enable");
    // R3 direction
    wr(A_DIR0, 32'h0000_00FF);
    obs(S_OE, 0, 32'h0000_00FF, "R3 padOe");
    obs(S_RD, A_DIR0, 32'h0000_00FF, "R3 direction readback");
    // R4 set, R5 clear, R2 word index
    wr(A_SET0, 32'h0000_00F0);
    obs(S_OUTLO, 0, 32'h0000_00F0, "R4 set");
    wr(A_SET0, 32'h0000_0001);
    obs(S_OUTLO, 0, 32'h0000_00F1, "R4 zeros untouched");
    wr(A_SET1, 32'h8000_0000);
    obs(S_OUTHI, 0, 32'h8000_0000, "R2 set word1 pin63");
    wr(A_CLR0, 32'h0000_0030);
    obs(S_OUTLO, 0, 32'h0000_00C1, "R5 clear");
    obs(S_RD, A_SET0, 32'h0, "R12 set reads zero");
    obs(S_RD, A_CLR0, 32'h0, "R12 clear reads zero");
    // R6 level
    setPad(64'h1234_5678_9ABC_DEF0);
    idle(3);
    obs(S_RD, A_LVL0, 32'h9ABC_DEF0, "R6 level word0");
    obs(S_RD, A_LVL1, 32'h1234_5678, "R6 level word1");
    wr(A_LVL0, 32'h0);
    obs(S_RD, A_LVL0, 32'h9ABC_DEF0, "R6 level write ignored");
    // Edges: pin0 rise, pin1 fall, pin2 both, pin3 none
    setPad('0);
    idle(4);
    wr(A_ST0, 32'hFFFF_FFFF);
    wr(A_RIS0, 32'h0000_0005);
    wr(A_FAL0, 32'h0000_0006);
    setPad(64'hF);
    idle(4);
    obs(S_RD, A_ST0, 32'h0000_0005, "R7 R13 rising capture");
    obs(S_IRQ, 0, 32'h1, "R9 irq high");
    setPad('0);
    idle(4);
    obs(S_RD, A_ST0, 32'h0000_0007, "R8 falling capture");
    wr(A_ST0, 32'h0000_0001);
    obs(S_RD, A_ST0, 32'h0000_0006, "R9 single clear");
    wr(A_ST0, 32'hFFFF_FFFF);
    obs(S_RD, A_ST0, 32'h0, "R9 all-ones clear");
    obs(S_IRQ, 0, 32'h0, "R9 irq low");
    // R10 edge vs clear collision on pin0
    setPad(64'h1);
    idle(4);
    obs(S_RD, A_ST0, 32'h1, "R10 precondition set");
    setPad('0);
    idle(4);
    obs(S_RD, A_ST0, 32'h1, "R13 R9 sticky, no fall enable");
    setPad(64'h1);
    @(posedge clk);
    wr(A_ST0, 32'h1);          // clear lands on the capture edge
    obs(S_RD, A_ST0, 32'h1, "R10 edge wins over clear");
    wr(A_ST0, 32'h1);
    obs(S_RD, A_ST0, 32'h0, "R9 clear without edge");
    // R2 high word pin 32
    wr(A_RIS1, 32'h1);
    setPad(64'h1_0000_0000);
    idle(4);
    obs(S_RD, A_ST1, 32'h1, "R2 status word1");
    obs(S_RD, A_ST0, 32'h0, "R13 pin0 fall not enabled");
    obs(S_IRQ, 0, 32'h1, "R9 irq from word1");
    wr(A_ST1, 32'hFFFF_FFFF);
    obs(S_IRQ, 0, 32'h0, "R9 irq cleared");
    // R11 function select
    wr(A_ALT1, 32'h0000_000C);
    obs(S_ALTHI, 0, 32'h0000_000C, "R11 pin17 field");
    obs(S_RD, A_ALT1, 32'h0000_000C, "R11 readback");
    wr(A_ALT3, 32'h8000_0000);
    obs(S_RD, A_ALT3, 32'h8000_0000, "R11 pin63 readback");
    // R12 out of range
    wr(A_OUT, 32'hFFFF_FFFF);
    wr(8'd200, 32'hFFFF_FFFF);
    obs(S_RD, A_OUT, 32'h0, "R12 out of range read");
    obs(S_RD, 8'd200, 32'h0, "R12 far read");
    obs(S_OE, 0, 32'h0000_00FF, "R12 direction untouched");
    obs(S_OUTLO, 0, 32'h0000_00C1, "R12 outputs untouched");
    obs(S_ALTLO, 0, 32'h0, "R12 select untouched");
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule